// File: doc/BRIEF.md
# Duplicate-on-Write DRAM Cache Controller

This block sequences the DRAM traffic of a cache whose modified lines are kept twice. When a line is written, the controller stores it in its own bank and then places a second copy in a partner bank half the bank count away. When a later read of a modified line is flagged by the external error checker, the line is recovered from that second copy, and the damaged original is rewritten. An unmodified line that fails its check is fetched again from main memory. Only modified lines need the extra copy, because main memory still holds a good copy of every unmodified line.

The controller handles one request at a time from a simple request port. It drives a single-command DRAM port and a main-memory fetch port, and it reads a per-read error flag from the checker. A two-bit protection level sets how much of this machinery is active. The level can be changed only while the cache reports itself flushed and the controller is idle. The tag array, the dirty state and the replacement policy live outside the block: each request carries the dirty bit of its line.

Top module: `dup_write_cache_ctl`

## Requirements
- R1: With protection level 3, a write issues a DRAM write to the home bank. In the next cycle it issues a DRAM write of the same data and row to the partner bank. The response pulse follows one cycle after the second write.
- R2: The partner bank is (bank + NUM_BANKS/2) mod NUM_BANKS. With 8 banks, bank 6 pairs with bank 2 and bank 1 pairs with bank 5.
- R3: At protection levels 0, 1 and 2, a write issues exactly one DRAM write, to the home bank, and no partner-bank access is made. No read ever creates a copy.
- R4: A read whose DRAM data comes back without an error flag returns that data with rsp_uncorr_o low, after exactly one DRAM read.
- R5: At levels 1 to 3, a read of a clean line (req_dirty_i low) that is flagged in error makes one main-memory fetch. It returns the fetched data and issues no DRAM write.
- R6: At level 3, a flagged read of a dirty line reads the partner bank. If that copy passes, its data is returned and rewritten to the home bank (one DRAM write).
- R7: At level 3, if both the home copy and the partner copy of a dirty line are flagged, the response has rsp_uncorr_o high and no DRAM write is issued.
- R8: At levels 1 and 2, a flagged read of a dirty line responds with rsp_uncorr_o high and does not access the partner bank.
- R9: At level 0 (no protection), the error flag is ignored and the DRAM data is returned with rsp_uncorr_o low.
- R10: Level codes are 0 none, 1 ECC, 2 ECC plus CRC, and 3 ECC plus CRC plus duplicate-on-write. A write of the level is taken only when flushed_i is high, the controller is idle and no request is presented; otherwise it is ignored.
- R11: An evict request (op code 2) of a dirty line at level 3 pulses dup_free_o with the partner bank in the response cycle, one cycle after acceptance. At other levels, or for a clean line, there is no pulse. An evict issues no DRAM command. Op code 1 is write; codes 0 and 3 are read.
- R12: After reset, req_ready_o is high and rsp_valid_o, dram_cmd_valid_o, mem_req_o and dup_free_o are low.
- R13: Only one request is outstanding. req_ready_o is low from acceptance until the response, and in any cycle at most one of DRAM command, memory fetch and response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr_i | input | 1 | Request to load a new protection level |
| mode_i | input | 2 | New protection level |
| flushed_i | input | 1 | Cache holds no valid lines; level change permitted |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 2 | 1 write, 2 evict, 0 or 3 read |
| req_bank_i | input | BANK_W | Home bank of the line |
| req_row_i | input | ROW_W | Row of the line |
| req_dirty_i | input | 1 | Line is modified (from the tag side) |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Controller idle, request accepted |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_data_o | output | DATA_W | Read result |
| rsp_uncorr_o | output | 1 | Uncorrectable error on this request |
| dram_cmd_valid_o | output | 1 | DRAM command this cycle |
| dram_we_o | output | 1 | Command is a write |
| dram_bank_o | output | BANK_W | Command bank |
| dram_row_o | output | ROW_W | Command row |
| dram_wdata_o | output | DATA_W | Write data |
| dram_rvalid_i | input | 1 | DRAM read data returned |
| dram_rdata_i | input | DATA_W | DRAM read data |
| dram_err_i | input | 1 | Checker flags the returned data |
| mem_req_o | output | 1 | Main-memory fetch request |
| mem_bank_o | output | BANK_W | Fetch bank field |
| mem_row_o | output | ROW_W | Fetch row field |
| mem_rvalid_i | input | 1 | Fetched data returned |
| mem_rdata_i | input | DATA_W | Fetched data |
| dup_free_o | output | 1 | Release the copy slot of an evicted dirty line |
| dup_free_bank_o | output | BANK_W | Bank of the released slot |

## Verification
The hardest paths to reach from the ports are the recovery paths. In the repair path the home copy fails and the partner copy passes. In the double-failure path both copies fail. Neither can occur unless the checker flags several accesses to one row in a set order. The bench's DRAM model keeps a fault flag for every bank and row. Each table entry plants faults on the home copy, on the partner copy, or on both before the read. A rewrite clears the flag, so the bench can then confirm that the repair restored the home bank with the copy's data.

// File: rtl/dow_pkg.sv
package dow_pkg;

   typedef enum logic [1:0] {
      MODE_NONE    = 2'd0,
      MODE_ECC     = 2'd1,
      MODE_ECC_CRC = 2'd2,
      MODE_DUP     = 2'd3
   } prot_mode_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_EVICT = 2'd2
   } req_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE_PRI,
      ST_WRITE_DUP,
      ST_READ,
      ST_READ_DUP,
      ST_REPAIR,
      ST_REFETCH,
      ST_ERROR
   } ctl_state_e;

endpackage

// File: rtl/dow_partner_map.sv
module dow_partner_map #(
   parameter int NUM_BANKS = 8
) (
   input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
   output logic [$clog2(NUM_BANKS)-1:0] partner_o
);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int HALF   = NUM_BANKS / 2;
   localparam bit POW2   = (NUM_BANKS == (1 << BANK_W));

   if (NUM_BANKS < 2 || (NUM_BANKS % 2) != 0) begin : g_bad_banks
      $error("dow_partner_map: NUM_BANKS must be even and at least 2");
   end

   if (POW2) begin : g_wrap
      // Power-of-two bank count: the adder wraps by itself.
      assign partner_o = bank_i + BANK_W'(HALF);
   end else begin : g_modulo
      logic [BANK_W:0] sum;
      assign sum       = {1'b0, bank_i} + (BANK_W+1)'(HALF);
      assign partner_o = (sum >= (BANK_W+1)'(NUM_BANKS))
                         ? BANK_W'(sum - (BANK_W+1)'(NUM_BANKS))
                         : BANK_W'(sum);
   end

   // The copy must never land in the bank it protects (R2).
   always_comb begin
      if (!$isunknown(bank_i))
         assert_partner_distinct_R2: assert (partner_o != bank_i);
   end

endmodule

// File: rtl/dow_mode_reg.sv
module dow_mode_reg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [1:0] mode_i,
   input  logic       flushed_i,
   input  logic       idle_i,
   output logic [1:0] mode_o
);
   logic [1:0] mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= 2'd0;
      else if (wr_i && flushed_i && idle_i)
         mode_q <= mode_i;
   end

   assign mode_o = mode_q;

   // The level only moves on an edge where a flushed, idle load was asked (R10).
   assert_mode_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_o) |-> $past(wr_i && flushed_i && idle_i));

endmodule

// File: rtl/dup_write_cache_ctl.sv
module dup_write_cache_ctl
   import dow_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 10,
   parameter int DATA_W    = 64,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr_i,
   input  logic [1:0]        mode_i,
   input  logic              flushed_i,
   input  logic              req_valid_i,
   input  logic [1:0]        req_op_i,
   input  logic [BANK_W-1:0] req_bank_i,
   input  logic [ROW_W-1:0]  req_row_i,
   input  logic              req_dirty_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              req_ready_o,
   output logic              rsp_valid_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic              rsp_uncorr_o,
   output logic              dram_cmd_valid_o,
   output logic              dram_we_o,
   output logic [BANK_W-1:0] dram_bank_o,
   output logic [ROW_W-1:0]  dram_row_o,
   output logic [DATA_W-1:0] dram_wdata_o,
   input  logic              dram_rvalid_i,
   input  logic [DATA_W-1:0] dram_rdata_i,
   input  logic              dram_err_i,
   output logic              mem_req_o,
   output logic [BANK_W-1:0] mem_bank_o,
   output logic [ROW_W-1:0]  mem_row_o,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              dup_free_o,
   output logic [BANK_W-1:0] dup_free_bank_o
);

   if (ROW_W < 1 || DATA_W < 1) begin : g_bad_widths
      $error("dup_write_cache_ctl: ROW_W and DATA_W must be positive");
   end

   ctl_state_e        state_q;
   logic [BANK_W-1:0] bank_q;
   logic [ROW_W-1:0]  row_q;
   logic              dirty_q;
   logic [DATA_W-1:0] data_q;
   logic              issued_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;
   logic              rsp_uncorr_q;
   logic              free_q;
   logic [BANK_W-1:0] free_bank_q;
   logic [BANK_W-1:0] partner_bank;
   logic [BANK_W-1:0] evict_partner;
   logic [1:0]        mode;
   logic              idle;
   logic              dup_on;

   assign idle   = (state_q == ST_IDLE);
   assign dup_on = (mode == MODE_DUP);

   dow_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (mode_wr_i),
      .mode_i    (mode_i),
      .flushed_i (flushed_i),
      .idle_i    (idle && !req_valid_i),
      .mode_o    (mode)
   );

   dow_partner_map #(.NUM_BANKS(NUM_BANKS)) u_dup_map (
      .bank_i    (bank_q),
      .partner_o (partner_bank)
   );

   dow_partner_map #(.NUM_BANKS(NUM_BANKS)) u_free_map (
      .bank_i    (req_bank_i),
      .partner_o (evict_partner)
   );

   // Command outputs decoded from the state.
   always_comb begin
      dram_cmd_valid_o = 1'b0;
      dram_we_o        = 1'b0;
      dram_bank_o      = bank_q;
      mem_req_o        = 1'b0;
      case (state_q)
         ST_WRITE_PRI: begin
            dram_cmd_valid_o = 1'b1;
            dram_we_o        = 1'b1;
         end
         ST_WRITE_DUP: begin
            dram_cmd_valid_o = 1'b1;
            dram_we_o        = 1'b1;
            dram_bank_o      = partner_bank;
         end
         ST_READ:      dram_cmd_valid_o = !issued_q;
         ST_READ_DUP: begin
            dram_cmd_valid_o = !issued_q;
            dram_bank_o      = partner_bank;
         end
         ST_REPAIR: begin
            dram_cmd_valid_o = 1'b1;
            dram_we_o        = 1'b1;
         end
         ST_REFETCH:   mem_req_o = !issued_q;
         default: ;
      endcase
   end

   assign dram_row_o   = row_q;
   assign dram_wdata_o = data_q;
   assign mem_bank_o   = bank_q;
   assign mem_row_o    = row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         bank_q       <= '0;
         row_q        <= '0;
         dirty_q      <= 1'b0;
         data_q       <= '0;
         issued_q     <= 1'b0;
         rsp_valid_q  <= 1'b0;
         rsp_data_q   <= '0;
         rsp_uncorr_q <= 1'b0;
         free_q       <= 1'b0;
         free_bank_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         free_q      <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  bank_q   <= req_bank_i;
                  row_q    <= req_row_i;
                  dirty_q  <= req_dirty_i;
                  issued_q <= 1'b0;
                  if (req_op_i == OP_WRITE) begin
                     data_q  <= req_wdata_i;
                     state_q <= ST_WRITE_PRI;
                  end else if (req_op_i == OP_EVICT) begin
                     rsp_valid_q  <= 1'b1;
                     rsp_data_q   <= '0;
                     rsp_uncorr_q <= 1'b0;
                     free_q       <= dup_on && req_dirty_i;
                     free_bank_q  <= evict_partner;
                  end else begin
                     state_q <= ST_READ;
                  end
               end
            end
            ST_WRITE_PRI: begin
               if (dup_on) begin
                  state_q <= ST_WRITE_DUP;
               end else begin
                  state_q      <= ST_IDLE;
                  rsp_valid_q  <= 1'b1;
                  rsp_data_q   <= data_q;
                  rsp_uncorr_q <= 1'b0;
               end
            end
            ST_WRITE_DUP: begin
               state_q      <= ST_IDLE;
               rsp_valid_q  <= 1'b1;
               rsp_data_q   <= data_q;
               rsp_uncorr_q <= 1'b0;
            end
            ST_READ: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (dram_rvalid_i) begin
                  issued_q <= 1'b0;
                  if (!dram_err_i || mode == MODE_NONE) begin
                     state_q      <= ST_IDLE;
                     rsp_valid_q  <= 1'b1;
                     rsp_data_q   <= dram_rdata_i;
                     rsp_uncorr_q <= 1'b0;
                  end else if (!dirty_q) begin
                     state_q <= ST_REFETCH;
                  end else if (dup_on) begin
                     state_q <= ST_READ_DUP;
                  end else begin
                     state_q <= ST_ERROR;
                  end
               end
            end
            ST_READ_DUP: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (dram_rvalid_i) begin
                  issued_q <= 1'b0;
                  if (dram_err_i) begin
                     state_q <= ST_ERROR;
                  end else begin
                     data_q  <= dram_rdata_i;
                     state_q <= ST_REPAIR;
                  end
               end
            end
            ST_REPAIR: begin
               state_q      <= ST_IDLE;
               rsp_valid_q  <= 1'b1;
               rsp_data_q   <= data_q;
               rsp_uncorr_q <= 1'b0;
            end
            ST_REFETCH: begin
               if (!issued_q) begin
                  issued_q <= 1'b1;
               end else if (mem_rvalid_i) begin
                  issued_q     <= 1'b0;
                  state_q      <= ST_IDLE;
                  rsp_valid_q  <= 1'b1;
                  rsp_data_q   <= mem_rdata_i;
                  rsp_uncorr_q <= 1'b0;
               end
            end
            ST_ERROR: begin
               state_q      <= ST_IDLE;
               rsp_valid_q  <= 1'b1;
               rsp_data_q   <= '0;
               rsp_uncorr_q <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o     = idle;
   assign rsp_valid_o     = rsp_valid_q;
   assign rsp_data_o      = rsp_data_q;
   assign rsp_uncorr_o    = rsp_uncorr_q;
   assign dup_free_o      = free_q;
   assign dup_free_bank_o = free_bank_q;

   // A home write under full protection is followed at once by the copy write (R1).
   assert_copy_follows_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE_PRI && dup_on) |=>
         (dram_cmd_valid_o && dram_we_o && dram_bank_o != bank_q));

   // Acknowledge comes only after the copy write was issued (R1).
   assert_ack_after_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WRITE_DUP) |=> (rsp_valid_o && !rsp_uncorr_o));

   // No partner-bank traffic below full protection (R3).
   assert_no_copy_unprotected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_on |-> !(state_q inside {ST_WRITE_DUP, ST_READ_DUP}));

   // A repair always uses data just read from the copy (R6).
   assert_repair_from_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REPAIR) |-> ($past(state_q) == ST_READ_DUP));

   // One activity at a time on the outgoing side (R13).
   assert_single_activity_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dram_cmd_valid_o, mem_req_o, rsp_valid_o}));

   // A response is only given with the controller free again (R13).
   assert_rsp_when_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> req_ready_o);

endmodule

// File: tb/dup_write_cache_ctl_bench.sv
module dup_write_cache_ctl_bench;

   localparam int NB = 8;
   localparam int RW = 10;
   localparam int DW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [1:0]    mode_v = 2'd0;
   logic          flushed = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [2:0]    req_bank = 3'd0;
   logic [RW-1:0] req_row = '0;
   logic          req_dirty = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid, rsp_uncorr;
   logic [DW-1:0] rsp_data;
   logic          dcmd, dwe;
   logic [2:0]    dbank;
   logic [RW-1:0] drow;
   logic [DW-1:0] dwdata;
   logic          drvalid = 1'b0;
   logic [DW-1:0] drdata = '0;
   logic          derr = 1'b0;
   logic          mreq;
   logic [2:0]    mbank;
   logic [RW-1:0] mrow;
   logic          mrvalid = 1'b0;
   logic [DW-1:0] mrdata = '0;
   logic          dfree;
   logic [2:0]    dfree_bank;

   dup_write_cache_ctl #(.NUM_BANKS(NB), .ROW_W(RW), .DATA_W(DW)) u_dup_write_cache_ctl (
      .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_i(mode_v), .flushed_i(flushed),
      .req_valid_i(req_valid), .req_op_i(req_op), .req_bank_i(req_bank), .req_row_i(req_row),
      .req_dirty_i(req_dirty), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
      .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_uncorr_o(rsp_uncorr),
      .dram_cmd_valid_o(dcmd), .dram_we_o(dwe), .dram_bank_o(dbank), .dram_row_o(drow),
      .dram_wdata_o(dwdata), .dram_rvalid_i(drvalid), .dram_rdata_i(drdata), .dram_err_i(derr),
      .mem_req_o(mreq), .mem_bank_o(mbank), .mem_row_o(mrow), .mem_rvalid_i(mrvalid),
      .mem_rdata_i(mrdata), .dup_free_o(dfree), .dup_free_bank_o(dfree_bank)
   );

   always #10 clk = ~clk;   // 50 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // DRAM and main-memory models with per-location fault flags.
   logic [DW-1:0] mem   [NB][16];
   logic          bad   [NB][16];
   int            n_wr, n_rd, n_fetch, n_free;
   logic [2:0]    wr_bank [4];
   int            wr_cyc  [4];
   logic [2:0]    seen_free_bank;

   function automatic logic [DW-1:0] pat(int k, int b, int r);
      return (64'(k) << 56) | (64'(b) << 8) | 64'(r) | 64'h0000_5A00_0000_0000;
   endfunction

   function automatic logic [2:0] partner(logic [2:0] b);
      return 3'((int'(b) + NB/2) % NB);
   endfunction

   initial begin
      logic       rd_pend, mf_pend;
      logic [2:0] pb, fb;
      logic [3:0] pr, fr;
      rd_pend = 1'b0;
      mf_pend = 1'b0;
      pb = '0; pr = '0; fb = '0; fr = '0;
      forever begin
         @(negedge clk);
         drvalid = rd_pend;
         if (rd_pend) begin
            drdata = mem[pb][pr];
            derr   = bad[pb][pr];
         end
         rd_pend = 1'b0;
         mrvalid = mf_pend;
         if (mf_pend) mrdata = pat(3, int'(fb), int'(fr));
         mf_pend = 1'b0;
         if (dcmd) begin
            if (dwe) begin
               mem[dbank][drow[3:0]] = dwdata;
               bad[dbank][drow[3:0]] = 1'b0;
               if (n_wr < 4) begin
                  wr_bank[n_wr] = dbank;
                  wr_cyc[n_wr]  = cyc;
               end
               n_wr++;
            end else begin
               rd_pend = 1'b1;
               pb = dbank;
               pr = drow[3:0];
               n_rd++;
            end
         end
         if (mreq) begin
            mf_pend = 1'b1;
            fb = mbank;
            fr = mrow[3:0];
            n_fetch++;
         end
         if (dfree) begin
            n_free++;
            seen_free_bank = dfree_bank;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   int rsp_cyc = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_log();
      n_wr = 0; n_rd = 0; n_fetch = 0; n_free = 0;
      for (int i = 0; i < 4; i++) begin
         wr_bank[i] = '0;
         wr_cyc[i]  = 0;
      end
      seen_free_bank = '0;
   endtask

   task automatic set_mode(logic [1:0] m, logic fl);
      @(negedge clk);
      mode_wr = 1'b1; mode_v = m; flushed = fl;
      @(negedge clk);
      mode_wr = 1'b0; flushed = 1'b0;
   endtask

   task automatic send(logic [1:0] op, logic [2:0] b, logic [3:0] r, logic d, logic [DW-1:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_bank = b; req_row = RW'(r);
      req_dirty = d; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(output bit got);
      got = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (rsp_valid) begin
            got = 1'b1;
            break;
         end
         @(negedge clk);
      end
      rsp_cyc = cyc;
      #1;
   endtask

   typedef struct packed {
      logic [3:0] req;
      logic [1:0] mode;
      logic [1:0] op;
      logic [2:0] bank;
      logic [3:0] row;
      logic       dirty;
      logic       bad_h;
      logic       bad_d;
      logic [2:0] src;     // 0 none, 1 home, 2 copy, 3 main memory, 4 written
      logic       unc;
      logic [1:0] nwr;
      logic [1:0] nrd;
      logic       nfetch;
      logic       nfree;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd1,  2'd3, 2'd1, 3'd1, 4'd5, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0}, // R1
      '{4'd2,  2'd3, 2'd1, 3'd6, 4'd3, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0}, // R2 wrap
      '{4'd3,  2'd1, 2'd1, 3'd2, 4'd7, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0}, // R3
      '{4'd4,  2'd3, 2'd0, 3'd3, 4'd1, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0}, // R4
      '{4'd5,  2'd3, 2'd0, 3'd0, 4'd2, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0}, // R5
      '{4'd6,  2'd3, 2'd0, 3'd5, 4'd4, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0}, // R6
      '{4'd7,  2'd3, 2'd0, 3'd7, 4'd6, 1'b1, 1'b1, 1'b1, 3'd0, 1'b1, 2'd0, 2'd2, 1'b0, 1'b0}, // R7
      '{4'd8,  2'd2, 2'd0, 3'd4, 4'd8, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0}, // R8
      '{4'd5,  2'd2, 2'd0, 3'd4, 4'd9, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 2'd0, 2'd1, 1'b1, 1'b0}, // R5 level 2
      '{4'd9,  2'd0, 2'd0, 3'd2, 4'd2, 1'b1, 1'b1, 1'b0, 3'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0}, // R9
      '{4'd11, 2'd3, 2'd2, 3'd5, 4'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1}, // R11
      '{4'd11, 2'd2, 2'd2, 3'd5, 4'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0}, // R11
      '{4'd11, 2'd3, 2'd2, 3'd3, 4'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0}  // R11 clean
   };

   // Watchdog: a hung run counts as a failure and still reports.
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R13 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      bit got;
      for (int b = 0; b < NB; b++)
         for (int r = 0; r < 16; r++) begin
            mem[b][r] = '0;
            bad[b][r] = 1'b0;
         end
      clear_log();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: idle state right after reset, before release
      chk("R12 ready in reset", 64'(req_ready), 64'd1);
      chk("R12 no rsp in reset", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 ready", 64'(req_ready), 64'd1);
      chk("R12 no dram cmd", 64'(dcmd), 64'd0);
      chk("R12 no fetch", 64'(mreq), 64'd0);
      chk("R12 no free", 64'(dfree), 64'd0);

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         logic [2:0] p;
         string tg;
         logic [DW-1:0] exp_d;
         t = VEC[v];
         p = partner(t.bank);
         tg = $sformatf("R%0d vec%0d", t.req, v);
         set_mode(t.mode, 1'b1);
         mem[t.bank][t.row] = pat(1, int'(t.bank), int'(t.row));
         mem[p][t.row]      = pat(2, int'(p), int'(t.row));
         bad[t.bank][t.row] = t.bad_h;
         bad[p][t.row]      = t.bad_d;
         clear_log();
         send(t.op, t.bank, t.row, t.dirty, pat(4, int'(t.bank), int'(t.row)));
         wait_rsp(got);
         chk({tg, " response"}, 64'(got), 64'd1);
         chk({tg, " uncorr"}, 64'(rsp_uncorr), 64'(t.unc));
         chk({tg, " dram writes"}, 64'(n_wr), 64'(t.nwr));
         chk({tg, " dram reads"}, 64'(n_rd), 64'(t.nrd));
         chk({tg, " fetches"}, 64'(n_fetch), 64'(t.nfetch));
         chk({tg, " frees"}, 64'(n_free), 64'(t.nfree));
         case (t.src)
            3'd1: exp_d = pat(1, int'(t.bank), int'(t.row));
            3'd2: exp_d = pat(2, int'(p), int'(t.row));
            3'd3: exp_d = pat(3, int'(t.bank), int'(t.row));
            default: exp_d = '0;
         endcase
         if (t.src inside {3'd1, 3'd2, 3'd3})
            chk({tg, " data"}, rsp_data, exp_d);
         if (t.src == 3'd4) begin
            chk({tg, " home written"}, mem[t.bank][t.row], pat(4, int'(t.bank), int'(t.row)));
            chk({tg, " first write home"}, 64'(wr_bank[0]), 64'(t.bank));
            if (t.nwr == 2'd2) begin
               chk({tg, " copy bank"}, 64'(wr_bank[1]), 64'(p));
               chk({tg, " copy data"}, mem[p][t.row], pat(4, int'(t.bank), int'(t.row)));
               chk({tg, " copy next cycle"}, 64'(wr_cyc[1]), 64'(wr_cyc[0] + 1));
               chk({tg, " ack after copy"}, 64'(rsp_cyc), 64'(wr_cyc[1] + 1));
            end else begin
               chk({tg, " partner untouched"}, mem[p][t.row], pat(2, int'(p), int'(t.row)));
            end
         end
         if (t.src == 3'd2) begin
            chk({tg, " repair bank"}, 64'(wr_bank[0]), 64'(t.bank));
            chk({tg, " home repaired"}, mem[t.bank][t.row], pat(2, int'(p), int'(t.row)));
         end
         if (t.nfree)
            chk({tg, " free bank"}, 64'(seen_free_bank), 64'(p));
      end

      // R13: busy while a read is outstanding
      set_mode(2'd3, 1'b1);
      clear_log();
      mem[3'd2][4'd3] = pat(1, 2, 3);
      bad[3'd2][4'd3] = 1'b0;
      send(2'd0, 3'd2, 4'd3, 1'b0, '0);
      chk("R13 not ready while busy", 64'(req_ready), 64'd0);
      wait_rsp(got);
      chk("R13 read completes", 64'(got), 64'd1);
      chk("R13 ready at response", 64'(req_ready), 64'd1);

      // R10: level load without flushed is ignored, level 3 stays
      set_mode(2'd1, 1'b0);
      clear_log();
      send(2'd1, 3'd0, 4'd11, 1'b0, pat(5, 0, 11));
      wait_rsp(got);
      chk("R10 unflushed load ignored", 64'(n_wr), 64'd2);
      // R10: flushed load takes effect
      set_mode(2'd1, 1'b1);
      clear_log();
      send(2'd1, 3'd0, 4'd12, 1'b0, pat(5, 0, 12));
      wait_rsp(got);
      chk("R10 flushed load applied", 64'(n_wr), 64'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule